// File: doc/BRIEF.md
# SDRAM Open-Row Tracker

This block records which row, if any, is currently open in every bank of every chip select behind an SDRAM memory controller. For each incoming access (chip select, internal bank, row) it states at once whether the row is already open (hit), whether the bank is idle (miss), or whether a different row is open and must be closed first (conflict). The controller can then skip the activate on a hit and plan a precharge on a conflict.

The command sequencer reports the commands it issues: activate (opens a bank with a row), precharge (closes one bank) and precharge-all (closes every bank of one chip select). A retention enable selects open-page operation. When it is low the table stays empty and every access is a miss. A low-power entry pulse, given when the memory clock enable is dropped, closes all pages. The default shape is four chip selects of four banks each, sixteen entries in all, with 15-bit rows.

Top module: `sdram_page_tracker`

## Requirements
- R1: After reset every entry is closed, so every lookup returns idle (2'b00).
- R2: `page_result` encodes idle as 2'b00, hit as 2'b01 and conflict as 2'b10. The value 2'b11 never appears.
- R3: An activate for (cs, bank, row) while retention is enabled opens that entry. From the next cycle a lookup of the same cs, bank and row returns hit, for any row value from 0 to 2^15-1. An activate on an entry that is already open replaces its row.
- R4: A lookup of an open entry with a different row returns conflict.
- R5: The entries are independent. Entry index is cs*4+bank, and a command on one entry leaves all other entries unchanged. All sixteen entries can be open at the same time.
- R6: A precharge for (cs, bank) closes only that entry.
- R7: A precharge-all for a chip select closes its four banks and leaves the other chip selects untouched.
- R8: While `retain_en` is low, every lookup returns idle, every edge clears the table, and activates are ignored. The table is therefore empty when retention returns.
- R9: A cycle with `lp_enter` high closes every entry at the next edge, whatever other command arrives in that cycle.
- R10: In one cycle the close operations take priority over an activate on the same entry. The order is low-power or retention off, then precharge-all, then precharge, then activate.
- R11: The lookup is combinational on the current table. A command changes lookups only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retain_en | input | 1 | Open-page retention enable |
| lp_enter | input | 1 | Low-power entry pulse, closes all pages |
| req_cs | input | 2 | Lookup chip select |
| req_bank | input | 2 | Lookup internal bank |
| req_row | input | 15 | Lookup row |
| page_result | output | 2 | 00 idle, 01 hit, 10 conflict |
| act_valid | input | 1 | Activate issued |
| act_cs | input | 2 | Activate chip select |
| act_bank | input | 2 | Activate bank |
| act_row | input | 15 | Activate row |
| pre_valid | input | 1 | Precharge issued |
| pre_cs | input | 2 | Precharge chip select |
| pre_bank | input | 2 | Precharge bank |
| prea_valid | input | 1 | Precharge-all issued |
| prea_cs | input | 2 | Precharge-all chip select |

## Verification
The assertions run on every cycle and cover the following: the result code stays legal, retention off forces idle, an edge after low-power entry leaves the looked-up entry closed, precharge and precharge-all close what they name, and an uncontested activate yields hit or conflict on the following cycle. The bench sweeps all sixteen entries with both the matching row and a differing row after each command pattern. This is the only check that shows one command leaves the other entries untouched, that an activate during disabled retention leaves nothing behind, and that same-cycle priority and combinational timing behave as stated.

// File: rtl/pgtrk_pkg.sv
package pgtrk_pkg;
  typedef enum logic [1:0] {
    PG_IDLE     = 2'b00,
    PG_HIT      = 2'b01,
    PG_CONFLICT = 2'b10
  } pg_result_e;
endpackage

// File: rtl/pgtrk_open_flags.sv
module pgtrk_open_flags #(
  parameter int NUM_CS = 4,
  parameter int BANKS  = 4,
  parameter int CS_W   = 2,
  parameter int BK_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      close_all,
  input  logic                      act_valid,
  input  logic [CS_W-1:0]           act_cs,
  input  logic [BK_W-1:0]           act_bank,
  input  logic                      pre_valid,
  input  logic [CS_W-1:0]           pre_cs,
  input  logic [BK_W-1:0]           pre_bank,
  input  logic                      prea_valid,
  input  logic [CS_W-1:0]           prea_cs,
  output logic [NUM_CS*BANKS-1:0]   open_q
);
  for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
    logic cs_prea;
    assign cs_prea = prea_valid && (prea_cs == CS_W'(c));
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic hit_pre, hit_act;
      assign hit_pre = pre_valid && (pre_cs == CS_W'(c)) && (pre_bank == BK_W'(b));
      assign hit_act = act_valid && (act_cs == CS_W'(c)) && (act_bank == BK_W'(b));
      always_ff @(posedge clk) begin
        if (rst || close_all)  open_q[c*BANKS+b] <= 1'b0;
        else if (cs_prea)      open_q[c*BANKS+b] <= 1'b0;
        else if (hit_pre)      open_q[c*BANKS+b] <= 1'b0;
        else if (hit_act)      open_q[c*BANKS+b] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pgtrk_row_store.sv
module pgtrk_row_store #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int ROW_W   = 15
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [ROW_W-1:0]  wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [ROW_W-1:0]  rdata
);
  logic [ROW_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pgtrk_classify.sv
module pgtrk_classify #(
  parameter int ROW_W = 15
) (
  input  logic             retain_en,
  input  logic             entry_open,
  input  logic [ROW_W-1:0] stored_row,
  input  logic [ROW_W-1:0] req_row,
  output pgtrk_pkg::pg_result_e result
);
  import pgtrk_pkg::*;
  always_comb begin
    if (!retain_en || !entry_open) result = PG_IDLE;
    else if (stored_row == req_row) result = PG_HIT;
    else                            result = PG_CONFLICT;
  end
endmodule

// File: rtl/sdram_page_tracker.sv
module sdram_page_tracker #(
  parameter int NUM_CS = 4,
  parameter int BANKS  = 4,
  parameter int ROW_W  = 15,
  localparam int CS_W    = $clog2(NUM_CS),
  localparam int BK_W    = $clog2(BANKS),
  localparam int IDX_W   = CS_W + BK_W,
  localparam int ENTRIES = NUM_CS * BANKS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             retain_en,
  input  logic             lp_enter,
  input  logic [CS_W-1:0]  req_cs,
  input  logic [BK_W-1:0]  req_bank,
  input  logic [ROW_W-1:0] req_row,
  output logic [1:0]       page_result,
  input  logic             act_valid,
  input  logic [CS_W-1:0]  act_cs,
  input  logic [BK_W-1:0]  act_bank,
  input  logic [ROW_W-1:0] act_row,
  input  logic             pre_valid,
  input  logic [CS_W-1:0]  pre_cs,
  input  logic [BK_W-1:0]  pre_bank,
  input  logic             prea_valid,
  input  logic [CS_W-1:0]  prea_cs
);
  logic                 close_all;
  logic [ENTRIES-1:0]   open_q;
  logic [ROW_W-1:0]     stored_row;
  logic [IDX_W-1:0]     req_idx, act_idx;
  pgtrk_pkg::pg_result_e result;

  assign close_all = lp_enter || !retain_en;
  assign req_idx   = {req_cs, req_bank};
  assign act_idx   = {act_cs, act_bank};

  pgtrk_open_flags #(.NUM_CS(NUM_CS), .BANKS(BANKS), .CS_W(CS_W), .BK_W(BK_W)) u_flags (
    .clk(clk), .rst(rst), .close_all(close_all),
    .act_valid(act_valid), .act_cs(act_cs), .act_bank(act_bank),
    .pre_valid(pre_valid), .pre_cs(pre_cs), .pre_bank(pre_bank),
    .prea_valid(prea_valid), .prea_cs(prea_cs), .open_q(open_q)
  );

  pgtrk_row_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .we(act_valid), .waddr(act_idx), .wdata(act_row),
    .raddr(req_idx), .rdata(stored_row)
  );

  pgtrk_classify #(.ROW_W(ROW_W)) u_cls (
    .retain_en(retain_en), .entry_open(open_q[req_idx]),
    .stored_row(stored_row), .req_row(req_row), .result(result)
  );

  assign page_result = result;
endmodule

// File: rtl/pgtrk_checker.sv
module pgtrk_checker #(
  parameter int CS_W  = 2,
  parameter int BK_W  = 2,
  parameter int ROW_W = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             retain_en,
  input logic             lp_enter,
  input logic [CS_W-1:0]  req_cs,
  input logic [BK_W-1:0]  req_bank,
  input logic [ROW_W-1:0] req_row,
  input logic [1:0]       page_result,
  input logic             act_valid,
  input logic [CS_W-1:0]  act_cs,
  input logic [BK_W-1:0]  act_bank,
  input logic [ROW_W-1:0] act_row,
  input logic             pre_valid,
  input logic [CS_W-1:0]  pre_cs,
  input logic [BK_W-1:0]  pre_bank,
  input logic             prea_valid,
  input logic [CS_W-1:0]  prea_cs
);
  assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst)
    page_result != 2'b11);

  assert_no_retain_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !retain_en |-> page_result == 2'b00);

  assert_lp_closes_R9: assert property (@(posedge clk) disable iff (rst)
    $past(lp_enter) |-> page_result == 2'b00);

  assert_pre_closes_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(pre_valid) && req_cs == $past(pre_cs) && req_bank == $past(pre_bank))
      |-> page_result == 2'b00);

  assert_prea_closes_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(prea_valid) && req_cs == $past(prea_cs)) |-> page_result == 2'b00);

  assert_act_hit_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(act_valid && retain_en && !lp_enter && !pre_valid && !prea_valid) && retain_en
     && req_cs == $past(act_cs) && req_bank == $past(act_bank) && req_row == $past(act_row))
      |-> page_result == 2'b01);

  assert_act_conflict_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(act_valid && retain_en && !lp_enter && !pre_valid && !prea_valid) && retain_en
     && req_cs == $past(act_cs) && req_bank == $past(act_bank) && req_row != $past(act_row))
      |-> page_result == 2'b10);
endmodule

bind sdram_page_tracker pgtrk_checker #(.CS_W(CS_W), .BK_W(BK_W), .ROW_W(ROW_W)) u_chk (.*);

// File: tb/sdram_page_tracker_bench.sv
`timescale 1ns/1ps
module sdram_page_tracker_bench;
  logic clk = 1'b0;
  logic rst, retain_en, lp_enter;
  logic [1:0] req_cs, req_bank, act_cs, act_bank, pre_cs, pre_bank, prea_cs;
  logic [14:0] req_row, act_row;
  logic act_valid, pre_valid, prea_valid;
  logic [1:0] page_result;

  int vectors = 0, errors = 0;
  bit done = 0;
  bit m_open [16];
  logic [14:0] m_row [16];

  always #4 clk = ~clk;

  sdram_page_tracker u_sdram_page_tracker (.*);

  function automatic logic [1:0] expect_res(int idx, logic [14:0] row);
    if (!retain_en || !m_open[idx]) return 2'b00;
    return (m_row[idx] == row) ? 2'b01 : 2'b10;
  endfunction

  task automatic check(int idx, logic [14:0] row, string tag);
    logic [1:0] e;
    req_cs = 2'(idx / 4); req_bank = 2'(idx % 4); req_row = row;
    #1;
    e = expect_res(idx, row);
    vectors++;
    if (page_result !== e || page_result === 2'b11) begin
      errors++;
      $display("FAIL %s entry %0d row %h: got %b expected %b", tag, idx, row, page_result, e);
    end
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < 16; i++) begin
      check(i, m_row[i], tag);
      check(i, m_row[i] ^ 15'h0001, tag);
    end
  endtask

  // Drive one cycle of commands; model update follows the stated priority (R10).
  task automatic step(bit av, int aidx, logic [14:0] arow, bit pv, int pidx,
                      bit pav, int pacs, bit lp);
    act_valid = av; act_cs = 2'(aidx / 4); act_bank = 2'(aidx % 4); act_row = arow;
    pre_valid = pv; pre_cs = 2'(pidx / 4); pre_bank = 2'(pidx % 4);
    prea_valid = pav; prea_cs = 2'(pacs); lp_enter = lp;
    @(negedge clk);
    if (lp || !retain_en) begin
      for (int i = 0; i < 16; i++) m_open[i] = 0;
    end else begin
      for (int i = 0; i < 16; i++) begin
        if (pav && i / 4 == pacs) m_open[i] = 0;
        else if (pv && i == pidx) m_open[i] = 0;
        else if (av && i == aidx) begin m_open[i] = 1; m_row[i] = arow; end
      end
    end
    act_valid = 0; pre_valid = 0; prea_valid = 0; lp_enter = 0;
  endtask

  task automatic act(int idx, logic [14:0] row);
    step(1, idx, row, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; retain_en = 1; lp_enter = 0;
    act_valid = 0; pre_valid = 0; prea_valid = 0;
    act_cs = 0; act_bank = 0; act_row = 0; pre_cs = 0; pre_bank = 0; prea_cs = 0;
    req_cs = 0; req_bank = 0; req_row = 0;
    for (int i = 0; i < 16; i++) begin m_open[i] = 0; m_row[i] = 15'(i * 3); end
    repeat (3) @(negedge clk);
    rst = 0;
    sweep("R1");

    // R5: open all sixteen entries with distinct rows
    for (int i = 0; i < 16; i++) act(i, 15'((i * 2731 + 17) & 32'h7fff));
    sweep("R5");
    // R3 boundary rows and replacement of an open row; R4 conflict against old row
    act(3, 15'h7fff); check(3, 15'h7fff, "R3"); check(3, 15'h0000, "R4");
    act(3, 15'h0000); check(3, 15'h0000, "R3"); check(3, 15'h7fff, "R4");
    sweep("R3");
    // R6
    step(0, 0, 0, 1, 5, 0, 0, 0); sweep("R6");
    // R7
    step(0, 0, 0, 0, 0, 1, 2, 0); sweep("R7");
    // R10: activate with precharge / precharge-all on the same entry
    step(1, 5, 15'h1234, 1, 5, 0, 0, 0); sweep("R10");
    step(1, 9, 15'h0abc, 0, 0, 1, 2, 0); sweep("R10");
    // R11: lookup unchanged before the edge, hit after it
    act_valid = 1; act_cs = 2'd1; act_bank = 2'd1; act_row = 15'h0555;
    check(5, 15'h0555, "R11");
    @(negedge clk);
    act_valid = 0; m_open[5] = 1; m_row[5] = 15'h0555;
    check(5, 15'h0555, "R11");
    // R8: retention off clears and ignores activates
    retain_en = 0;
    check(0, m_row[0], "R8");
    step(1, 7, 15'h0777, 0, 0, 0, 0, 0);
    sweep("R8");
    retain_en = 1;
    sweep("R8");
    // R9: low-power entry closes everything, even with an activate in flight
    for (int i = 0; i < 16; i += 3) act(i, 15'(i * 1001));
    sweep("R9");
    step(1, 4, 15'h0044, 0, 0, 0, 0, 1);
    sweep("R9");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule